// File: doc/BRIEF.md
# Transport packet sync detector

This block takes the serial hard-decision bit stream that comes out of an inner convolutional decoder and finds the packet framing in it. It does not assume the stream starts on a byte edge. Every accepted bit shifts into an 8-bit window, so the sync byte can be found at any of the eight bit offsets. A candidate can be the programmable sync value or its bitwise complement. Once the same framing has been confirmed several times, the block enters lock. It then delivers whole bytes with a strobe, so that a downstream deinterleaver, outer block decoder and descrambler can all align to the same packet edges.

The framing period is `FRAME_LEN` bytes, 204 by default, and the sync byte is the first byte of each frame. The tracker moves through three states: hunt, verify and lock. Lock needs `LOCK_HITS` (3) consecutive syncs spaced exactly one frame apart. Lock is lost after `LOSS_MISSES` (4) consecutive missing syncs. While locked, the start-of-packet marker keeps its place through missing syncs. A complemented sync byte raises a flag that marks the start of a superframe.

The stream can come from a two-phase or a four-phase demodulator. Either way the block only sees bits, so both polarities of the sync byte count toward lock. The recommended sync value is 0x47, whose complement is 0xB8.

Top module: `pkt_sync_detector`

## Requirements
- R1: After a reset, `locked`, `byte_valid`, `sof` and `inv_sync` are all low.
- R2: A bit is taken from `bit_in` only in a cycle where `bit_valid` is high. Bytes are formed MSB first. Cycles with `bit_valid` low change nothing, and `byte_valid` is never high in the cycle after such a cycle.
- R3: While hunting, the last 8 accepted bits are compared with `sync_pattern` and with its complement at every bit offset. No match is taken before 8 bits have been accepted since reset.
- R4: Lock is declared on the third consecutive sync match, with the matches spaced exactly FRAME_LEN*8 accepted bits apart. A missing sync during verification returns the block to hunting and restarts the count.
- R5: Bytes are emitted only in lock. `byte_valid` is high for one cycle, in the cycle after the eighth bit of each byte is accepted. `byte_out` holds those 8 bits, first-received bit in bit 7.
- R6: `sof` is high together with `byte_valid` on the first byte of every frame, and on no other byte. Consecutive `sof` pulses are FRAME_LEN bytes apart while locked.
- R7: `inv_sync` is high together with `sof` when the frame's first byte equals the complement of `sync_pattern`, and low otherwise. A complemented sync counts as a match for acquisition and tracking.
- R8: In lock, a frame whose first byte does not match still gets `sof`. The fourth consecutive miss clears `locked` in the same cycle as that frame's `sof`. Any match resets the miss count.
- R9: The sync value is taken from `sync_pattern`. Sync bytes are passed out as received, not rewritten.
- R10: `locked` rises in the same cycle as the first `byte_valid`, which carries the third sync byte with `sof` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_in | input | 1 | Serial decoded bit |
| bit_valid | input | 1 | Qualifies `bit_in` in this cycle |
| sync_pattern | input | 8 | Programmable sync byte value |
| byte_out | output | 8 | Aligned byte, first-received bit in bit 7 |
| byte_valid | output | 1 | One-cycle strobe for `byte_out` |
| sof | output | 1 | First byte of a frame |
| inv_sync | output | 1 | Frame starts with complemented sync (superframe start) |
| locked | output | 1 | Framing is locked |

## Verification
The bench starts the first sync after each of several bit offsets, inverts it in different frames, changes the sync value, and inserts idle cycles between bits. A design that slipped by a bit, or that let idle cycles shift the window, would give wrong bytes or fail to lock. One case breaks verification with a bad sync after two good ones. A design that kept its hit count would then lock one frame too early. The lock-loss sequence puts three misses, a good sync and three more misses before the fourth miss in a row. A design that never cleared its miss count would drop lock too soon. A design that dropped lock late, or stopped marking frames during misses, would also show up. Finally, a sync value of 0x07 is placed in the first three bits after reset. A design without the window-fill guard would take it as a sync and lock one frame early.

// File: rtl/pkt_sync_pkg.sv
// Shared types for the packet sync detector.
// Assumes sync bytes are 8 bits wide and frames are a whole number of bytes.
package pkt_sync_pkg;

    localparam int SYNC_BITS = 8;

    typedef enum logic [1:0] {
        ST_HUNT   = 2'd0,
        ST_VERIFY = 2'd1,
        ST_LOCK   = 2'd2
    } trk_state_t;

    typedef struct packed {
        logic hit_true;
        logic hit_inv;
    } sync_hit_t;

endpackage

// File: rtl/pss_window.sv
// Sliding bit window: shifts in each accepted bit and compares the window
// against the sync value and its complement.
// Assumes: bit_in is meaningful only when bit_valid is high. A match is
// suppressed until SYNC_W bits have been accepted since reset.
module pss_window
    import pkt_sync_pkg::*;
#(
    parameter int SYNC_W = SYNC_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_in,
    input  logic              bit_valid,
    input  logic [SYNC_W-1:0] pattern,
    output logic [SYNC_W-1:0] win_next,
    output sync_hit_t         hit
);

    localparam int FILL_W = $clog2(SYNC_W);
    localparam logic [FILL_W-1:0] FILL_LAST = FILL_W'(SYNC_W - 1);

    logic [SYNC_W-1:0] win_q;
    logic [FILL_W-1:0] fill_q;
    logic              full;

    // Window as it stands once the current bit is included.
    assign win_next = {win_q[SYNC_W-2:0], bit_in};
    assign full     = (fill_q == FILL_LAST);

    // Compare against both polarities of the sync value.
    always_comb begin
        hit.hit_true = bit_valid && full && (win_next == pattern);
        hit.hit_inv  = bit_valid && full && (win_next == ~pattern);
    end

    // Shift register that advances only on accepted bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q <= '0;
        end else if (bit_valid) begin
            win_q <= win_next;
        end
    end

    // Count accepted bits until the window holds real data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_q <= '0;
        end else if (bit_valid && !full) begin
            fill_q <= fill_q + 1'b1;
        end
    end

    // R2
    win_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_valid |=> $stable(win_q));

endmodule

// File: rtl/pss_tracker.sv
// Frame tracker: hunt / verify / lock state machine with a bit counter
// that spans one frame. It decides which accepted bits end a byte to
// emit, and which end a frame.
// Assumes: LOCK_HITS >= 2, LOSS_MISSES >= 1, and the hit inputs are
// already qualified by bit_valid.
module pss_tracker
    import pkt_sync_pkg::*;
#(
    parameter int FRAME_LEN   = 204,
    parameter int LOCK_HITS   = 3,
    parameter int LOSS_MISSES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_valid,
    input  sync_hit_t  hit,
    output trk_state_t state,
    output logic       emit,
    output logic       sof_ev,
    output logic       inv_ev
);

    localparam int FRAME_BITS = FRAME_LEN * SYNC_BITS;
    localparam int CNT_W      = $clog2(FRAME_BITS);
    localparam int HIT_W      = $clog2(LOCK_HITS + 1);
    localparam int MISS_W     = $clog2(LOSS_MISSES + 1);
    localparam int LANE_W     = $clog2(SYNC_BITS);
    localparam logic [CNT_W-1:0]  CNT_LAST  = CNT_W'(FRAME_BITS - 1);
    localparam logic [HIT_W-1:0]  HIT_LAST  = HIT_W'(LOCK_HITS - 1);
    localparam logic [MISS_W-1:0] MISS_LAST = MISS_W'(LOSS_MISSES - 1);

    trk_state_t        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [HIT_W-1:0]  hits_q, hits_d;
    logic [MISS_W-1:0] miss_q, miss_d;
    logic              any_hit, frame_end, byte_end, lock_now;

    // Boundary decode from the bit counter.
    assign any_hit   = hit.hit_true | hit.hit_inv;
    assign frame_end = bit_valid && (cnt_q == CNT_LAST);
    assign byte_end  = bit_valid && (&cnt_q[LANE_W-1:0]);
    assign lock_now  = (state_q == ST_VERIFY) && frame_end && any_hit
                       && (hits_q == HIT_LAST);

    // Next-state and counter update for the acquisition hysteresis.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        hits_d  = hits_q;
        miss_d  = miss_q;
        unique case (state_q)
            ST_HUNT: begin
                cnt_d = '0;
                if (any_hit) begin
                    state_d = ST_VERIFY;
                    hits_d  = HIT_W'(1);
                end
            end
            ST_VERIFY: begin
                if (frame_end) begin
                    cnt_d = '0;
                    if (!any_hit) begin
                        state_d = ST_HUNT;
                    end else if (lock_now) begin
                        state_d = ST_LOCK;
                        miss_d  = '0;
                    end else begin
                        hits_d = hits_q + 1'b1;
                    end
                end else if (bit_valid) begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_LOCK: begin
                if (frame_end) begin
                    cnt_d = '0;
                    if (any_hit) begin
                        miss_d = '0;
                    end else if (miss_q == MISS_LAST) begin
                        state_d = ST_HUNT;
                        miss_d  = '0;
                    end else begin
                        miss_d = miss_q + 1'b1;
                    end
                end else if (bit_valid) begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: state_d = ST_HUNT;
        endcase
    end

    // State, counter and hysteresis registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
            cnt_q   <= '0;
            hits_q  <= '0;
            miss_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            hits_q  <= hits_d;
            miss_q  <= miss_d;
        end
    end

    // Output events: bytes flow in lock and on the bit that declares lock.
    assign emit   = byte_end && ((state_q == ST_LOCK) || lock_now);
    assign sof_ev = emit && frame_end;
    assign inv_ev = sof_ev && hit.hit_inv;
    assign state  = state_q;

    // R4
    hunt_to_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HUNT) |=> (state_q != ST_LOCK));

    // R8
    lock_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_LOCK) && !frame_end) |=> (state_q == ST_LOCK));

endmodule

// File: rtl/pss_emitter.sv
// Output stage: registers the aligned byte and its markers for one cycle
// per emitted byte.
// Assumes: emit, sof_ev and inv_ev arrive in the cycle the last bit of a
// byte is accepted. locked has the same register timing as these outputs.
module pss_emitter
    import pkt_sync_pkg::*;
#(
    parameter int FRAME_LEN = 204
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 emit,
    input  logic                 sof_ev,
    input  logic                 inv_ev,
    input  logic                 locked,
    input  logic [SYNC_BITS-1:0] win_next,
    output logic [SYNC_BITS-1:0] byte_out,
    output logic                 byte_valid,
    output logic                 sof,
    output logic                 inv_sync
);

    localparam int BC_W = $clog2(FRAME_LEN + 1);

    // Strobe and marker registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_valid <= 1'b0;
            sof        <= 1'b0;
            inv_sync   <= 1'b0;
        end else begin
            byte_valid <= emit;
            sof        <= sof_ev;
            inv_sync   <= inv_ev;
        end
    end

    // Data register, loaded only when a byte is emitted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_out <= '0;
        end else if (emit) begin
            byte_out <= win_next;
        end
    end

    // Checker state: bytes seen since the last frame start while locked.
    logic [BC_W-1:0] bcnt_q;
    logic            seen_q;

    // Counts emitted bytes between frame starts for the spacing check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bcnt_q <= '0;
            seen_q <= 1'b0;
        end else if (!locked && !byte_valid) begin
            seen_q <= 1'b0;
        end else if (byte_valid && sof) begin
            seen_q <= 1'b1;
            bcnt_q <= BC_W'(1);
        end else if (byte_valid) begin
            bcnt_q <= bcnt_q + 1'b1;
        end
    end

    // R6
    sof_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sof |-> byte_valid);

    // R7
    inv_needs_sof_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_sync |-> sof);

    // R6
    sof_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && sof && seen_q) |-> (bcnt_q == BC_W'(FRAME_LEN)));

    // R6
    sof_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && seen_q && (bcnt_q == BC_W'(FRAME_LEN))) |-> sof);

endmodule

// File: rtl/pkt_sync_detector.sv
// Top of the packet sync detector: serial bits in, aligned bytes with
// frame markers out.
// Assumes: one bit per cycle at most, and a sync value that differs from
// its complement (always true for 8 bits).
module pkt_sync_detector
    import pkt_sync_pkg::*;
#(
    parameter int FRAME_LEN   = 204,
    parameter int LOCK_HITS   = 3,
    parameter int LOSS_MISSES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bit_in,
    input  logic                 bit_valid,
    input  logic [SYNC_BITS-1:0] sync_pattern,
    output logic [SYNC_BITS-1:0] byte_out,
    output logic                 byte_valid,
    output logic                 sof,
    output logic                 inv_sync,
    output logic                 locked
);

    logic [SYNC_BITS-1:0] win_next;
    sync_hit_t            hit;
    trk_state_t           state;
    logic                 emit, sof_ev, inv_ev;

    pss_window #(
        .SYNC_W (SYNC_BITS)
    ) u_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_in    (bit_in),
        .bit_valid (bit_valid),
        .pattern   (sync_pattern),
        .win_next  (win_next),
        .hit       (hit)
    );

    pss_tracker #(
        .FRAME_LEN   (FRAME_LEN),
        .LOCK_HITS   (LOCK_HITS),
        .LOSS_MISSES (LOSS_MISSES)
    ) u_tracker (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_valid (bit_valid),
        .hit       (hit),
        .state     (state),
        .emit      (emit),
        .sof_ev    (sof_ev),
        .inv_ev    (inv_ev)
    );

    // Lock flag comes straight from the tracker state register.
    assign locked = (state == ST_LOCK);

    pss_emitter #(
        .FRAME_LEN (FRAME_LEN)
    ) u_emitter (
        .clk        (clk),
        .rst_n      (rst_n),
        .emit       (emit),
        .sof_ev     (sof_ev),
        .inv_ev     (inv_ev),
        .locked     (locked),
        .win_next   (win_next),
        .byte_out   (byte_out),
        .byte_valid (byte_valid),
        .sof        (sof),
        .inv_sync   (inv_sync)
    );

    // R2
    valid_follows_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |-> $past(bit_valid));

    // R10
    lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> (sof && byte_valid));

    // R8
    lock_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked) |-> (sof && !inv_sync));

    // R5
    valid_only_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |-> (locked || $past(locked)));

endmodule

// File: tb/test_pkt_sync_detector.sv
// Self-checking bench for pkt_sync_detector: a vector table walked by one
// loop, then directed tests for verify failure, lock loss, reset and
// window fill.
module test_pkt_sync_detector;

    localparam int CLK_PERIOD = 10;
    localparam int FRAME_LEN  = 204;
    localparam int NV         = 6;
    // Fields: pattern[23:16], zero-bit prefix[15:13],
    // inverted-frame mask[12:9] (bit k = frame k), idle gaps[8], seed[7:0]
    localparam logic [23:0] VECS [NV] = '{
        {8'h47, 3'd0, 4'b0000, 1'b0, 8'h11},
        {8'h47, 3'd3, 4'b0001, 1'b0, 8'h5A},
        {8'h47, 3'd7, 4'b0100, 1'b0, 8'hC3},
        {8'h1B, 3'd5, 4'b1010, 1'b0, 8'h2E},
        {8'hA5, 3'd1, 4'b1000, 1'b1, 8'h77},
        {8'hB8, 3'd2, 4'b0011, 1'b0, 8'h90}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_in = 1'b0;
    logic       bit_valid = 1'b0;
    logic [7:0] sync_pattern = 8'h47;
    logic [7:0] byte_out;
    logic       byte_valid, sof, inv_sync, locked;

    int tests = 0;
    int fails = 0;
    int stray = 0;
    logic [7:0] o_byte;
    logic       o_valid, o_sof, o_inv, o_locked;
    logic [7:0] s_byte;
    logic       s_sof, s_inv, s_locked;

    pkt_sync_detector #(
        .FRAME_LEN (FRAME_LEN)
    ) i_pkt_sync_detector (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_in       (bit_in),
        .bit_valid    (bit_valid),
        .sync_pattern (sync_pattern),
        .byte_out     (byte_out),
        .byte_valid   (byte_valid),
        .sof          (sof),
        .inv_sync     (inv_sync),
        .locked       (locked)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst_n     = 1'b0;
        bit_valid = 1'b0;
        bit_in    = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic send_bit(input logic b, input logic gap);
        if (gap) begin
            @(negedge clk);
            bit_valid = 1'b0;
            bit_in    = 1'b1;
            @(posedge clk);
            #1;
            if (byte_valid) stray++;
        end
        @(negedge clk);
        bit_in    = b;
        bit_valid = 1'b1;
        @(posedge clk);
        #1;
        o_byte   = byte_out;
        o_valid  = byte_valid;
        o_sof    = sof;
        o_inv    = inv_sync;
        o_locked = locked;
    endtask

    task automatic send_byte(input logic [7:0] b, input logic gap);
        for (int i = 7; i >= 0; i--) begin
            send_bit(b[i], gap);
            if (i != 0 && o_valid) stray++;
        end
    endtask

    task automatic send_frame(input logic [7:0] sb);
        send_byte(sb, 1'b0);
        s_byte   = o_byte;
        s_sof    = o_sof;
        s_inv    = o_inv;
        s_locked = o_locked;
        for (int j = 1; j < FRAME_LEN; j++) send_byte(8'h00, 1'b0);
    endtask

    function automatic logic [7:0] dbyte(input logic [7:0] seed, input int k, input int j);
        return seed ^ 8'(k * 29) ^ 8'(j * 7);
    endfunction

    task automatic summary;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog (run did not finish): actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] pat, sb, db, seed;
        logic [2:0] pre;
        logic [3:0] inv;
        logic       gap;
        int         mism;

        // R1: reset state
        do_reset();
        check("R1 locked after reset", locked, 0);
        check("R1 byte_valid after reset", byte_valid, 0);
        check("R1 sof after reset", sof, 0);
        check("R1 inv_sync after reset", inv_sync, 0);

        // Vector table: offsets, polarities, patterns, idle gaps
        for (int v = 0; v < NV; v++) begin
            pat  = VECS[v][23:16];
            pre  = VECS[v][15:13];
            inv  = VECS[v][12:9];
            gap  = VECS[v][8];
            seed = VECS[v][7:0];
            sync_pattern = pat;
            do_reset();
            for (int p = 0; p < int'(pre); p++) send_bit(1'b0, gap);
            stray = 0;
            for (int k = 0; k < 4; k++) begin
                sb = inv[k] ? ~pat : pat;
                send_byte(sb, gap);
                if (k < 2) begin
                    check("R4 no lock before third sync", o_locked, 0);
                    check("R5 no byte before lock", o_valid, 0);
                end else begin
                    check("R10 locked on sync byte", o_locked, 1);
                    check("R6 sof on frame start", o_sof, 1);
                    check("R9 sync byte passed as received", o_byte, sb);
                    check("R7 inverted sync flag", o_inv, inv[k]);
                end
                if (k < 3) begin
                    mism = 0;
                    for (int j = 1; j < FRAME_LEN; j++) begin
                        db = dbyte(seed, k, j);
                        send_byte(db, gap);
                        if (k == 2 && (!o_valid || o_byte != db || o_sof || o_inv)) mism++;
                    end
                    if (k == 2) check("R5 payload bytes aligned", mism, 0);
                end
            end
            check("R2 strobe only after eighth accepted bit", stray, 0);
        end

        // R1: reset while locked
        do_reset();
        check("R1 locked cleared by reset", locked, 0);

        // R4: a miss during verification restarts the count
        sync_pattern = 8'h47;
        do_reset();
        send_frame(8'h47);
        send_frame(8'h47);
        send_frame(8'h00);
        send_frame(8'h47);
        check("R4 restart after verify miss (1)", s_locked, 0);
        send_frame(8'h47);
        check("R4 restart after verify miss (2)", s_locked, 0);
        send_frame(8'h47);
        check("R4 lock after restart", s_locked, 1);

        // R8: flywheel through misses, reset of miss count, drop on fourth
        for (int m = 0; m < 3; m++) begin
            send_frame(8'h00);
            check("R8 lock held through miss", s_locked, 1);
            check("R8 sof kept on missed sync", s_sof, 1);
            check("R8 missed sync byte as received", s_byte, 8'h00);
        end
        send_frame(8'hB8);
        check("R7 complement keeps lock", s_locked, 1);
        check("R7 complement flagged", s_inv, 1);
        for (int m = 0; m < 3; m++) begin
            send_frame(8'h00);
            check("R8 miss count cleared by match", s_locked, 1);
        end
        send_frame(8'h00);
        check("R8 lock dropped on fourth miss", s_locked, 0);
        check("R8 sof on dropping frame", s_sof, 1);
        check("R8 no inverted flag on miss", s_inv, 0);

        // R3: no match before the window has been filled
        sync_pattern = 8'h07;
        do_reset();
        for (int i = 0; i < 3; i++) send_bit(1'b1, 1'b0);
        for (int p = 0; p < 3; p++) begin
            for (int i = 0; i < FRAME_LEN * 8 - 3; i++) send_bit(1'b0, 1'b0);
            for (int i = 0; i < 3; i++) send_bit(1'b1, 1'b0);
            if (p == 1) check("R3 partial window ignored", o_locked, 0);
            if (p == 2) check("R3 lock on true syncs", o_locked, 1);
        end

        do_reset();
        summary();
        $finish;
    end

endmodule